// File: doc/BRIEF.md
# Serial Management Frame Master (MDC/MDIO)

This block runs single register accesses on an Ethernet PHY over a two-wire serial management bus. It generates the management clock, drives the data line with an output-enable, and reads the data line back. A host places a read/write flag, a 5-bit PHY address, a 5-bit register index and 16 bits of write data on its inputs and pulses a start strobe. The block sends a 32-cycle all-ones preamble and then the frame. It returns read data and an error flag together with a one-cycle done pulse.

Every frame bit takes three equal phases of `PHASE_CLKS` system clocks each: clock low with the data set up, clock high, and clock low again. A read releases the data line at the start of the first turnaround bit, while the management clock is low. The block takes the PHY's level after the first turnaround pulse as an error indication. It then gives one more pulse and captures 16 data bits. A high error level forces the returned data to zero. A write keeps the line driven for the whole frame. Both kinds of access end with the line driven again.

Top module: `mdio_master`

## Requirements
- R1: Out of reset and whenever no access is in progress, `mdc` is 0, `mdioOe` is 1, `mdioOut` is 1, and `busy` and `done` are 0.
- R2: Each access begins with 32 rising edges of `mdc` during which `mdioOe` is 1 and `mdioOut` is 1.
- R3: After the preamble, the block drives the start code 01, then the opcode, then `phyAddr` and `regAddr`, each field most significant bit first and taken on the rising edge of `mdc`. The opcode is 10 for a read (`isWrite`=0) and 01 for a write (`isWrite`=1).
- R4: `mdc` is high for PHASE_CLKS system clocks in each bit and low for 2*PHASE_CLKS clocks. The cycle in which `done` is 1 follows the accepting clock edge by exactly 64*3*PHASE_CLKS clock edges, for reads and writes alike.
- R5: On a write, the block drives the turnaround pattern 10 after the register index, followed by `wrData` MSB first. That makes exactly 64 rising `mdc` edges with `mdioOe` at 1 and none with it at 0.
- R6: On a read, `mdioOe` falls while `mdc` is 0, directly after the 14th frame bit. The read ends after exactly 18 rising `mdc` edges with `mdioOe` at 0.
- R7: On a read, the block samples `mdioIn` after the first turnaround pulse and before the second. A 1 at that sample sets `errOut` to 1 and `rdData` to 0.
- R8: On a read, the block samples the data bits most significant first, each one just before its rising `mdc` edge. The first sample falls after the second turnaround pulse. With no error, `rdData` returns the 16 captured bits and `errOut` is 0.
- R9: `done` is 1 for exactly one system clock per access, and `busy` is 1 from the accepting edge through that cycle. `rdData` and `errOut` are updated in that cycle and hold until the next access finishes. A write returns `rdData`=0 and `errOut`=0.
- R10: A start pulse that arrives while `busy` is 1 has no effect: the frame on the bus, the number of `done` pulses and the returned values are those of the access already running.
- R11: In the clock after `done`, `mdioOe` is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rstN | input | 1 | Active-low asynchronous reset |
| startIn | input | 1 | Start strobe, taken only when idle |
| isWrite | input | 1 | 1 for a write access, 0 for a read access |
| phyAddr | input | 5 | PHY address |
| regAddr | input | 5 | Register index 0..31 |
| wrData | input | 16 | Write data |
| mdioIn | input | 1 | Level seen on the management data line |
| busy | output | 1 | Access in progress |
| done | output | 1 | One-cycle completion pulse |
| rdData | output | 16 | Read result, zero after an error or a write |
| errOut | output | 1 | Read error flag |
| mdc | output | 1 | Management clock |
| mdioOut | output | 1 | Data line output level |
| mdioOe | output | 1 | Data line output enable |

## Verification
The bench sweeps all 32 PHY addresses through writes and reads. It pairs each address with the complementary register index and with data values computed arithmetically, so a misplaced or reversed bit in any field changes the frame it records. Reads are run with the PHY model signalling an error on every fifth address, which separates the zero-forcing path from normal capture of the same data. A start pulse given in the middle of a running access, with different fields, shows whether a request can be accepted while busy. Latency and edge counts separate a wrong phase length or a missing turnaround pulse from a fault in the frame itself.

// File: rtl/mdio_master_pkg.sv
package mdio_master_pkg;

  localparam int ADDR_W     = 5;
  localparam int REG_W      = 5;
  localparam int DATA_W     = 16;
  localparam int CODE_W     = 2;
  localparam int HDR_BITS   = 2 * CODE_W + ADDR_W + REG_W;
  localparam int FRAME_BITS = HDR_BITS + CODE_W + DATA_W;
  localparam int TURN_BITS  = 2;

  localparam logic [CODE_W-1:0] START_CODE = 2'b01;
  localparam logic [CODE_W-1:0] OP_READ    = 2'b10;
  localparam logic [CODE_W-1:0] OP_WRITE   = 2'b01;
  localparam logic [CODE_W-1:0] WR_TURN    = 2'b10;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_PRE,
    ST_FRAME,
    ST_TURN,
    ST_CAPT,
    ST_FIN
  } seq_state_t;

  typedef struct packed {
    logic load;        // accept request into datapath
    logic shiftOut;    // advance transmit shift register
    logic driveFrame;  // frame bits on the line (else idle/preamble one)
    logic grabErr;     // sample error level
    logic grabBit;     // sample one read data bit
    logic finish;      // publish results
  } strobe_t;

endpackage

// File: rtl/mdio_master_ctrl.sv
module mdio_master_ctrl
  import mdio_master_pkg::*;
#(
  parameter int PHASE_CLKS = 4,
  parameter int PRE_LEN    = 32
) (
  input  logic    clk,
  input  logic    rstN,
  input  logic    startIn,
  input  logic    isWrite,
  output logic    busy,
  output logic    done,
  output logic    mdc,
  output logic    mdioOe,
  output strobe_t stb
);

  localparam int TW     = (PHASE_CLKS > 1) ? $clog2(PHASE_CLKS) : 1;
  localparam int MAXLEN = (PRE_LEN > FRAME_BITS) ? PRE_LEN : FRAME_BITS;
  localparam int CW     = $clog2(MAXLEN) + 1;

  localparam logic [TW-1:0] TICK_LAST = TW'(PHASE_CLKS - 1);
  localparam logic [CW-1:0] PRE_LAST  = CW'(PRE_LEN - 1);
  localparam logic [CW-1:0] WR_LAST   = CW'(FRAME_BITS - 1);
  localparam logic [CW-1:0] RD_LAST   = CW'(HDR_BITS - 1);
  localparam logic [CW-1:0] TURN_LAST = CW'(TURN_BITS - 1);
  localparam logic [CW-1:0] DATA_LAST = CW'(DATA_W - 1);

  seq_state_t   state;
  logic [TW-1:0] tick;
  logic [1:0]    phase;
  logic [CW-1:0] bitCnt;
  logic          wrLatched;

  logic phaseEnd;
  logic bitEnd;
  logic running;
  logic [CW-1:0] frameLast;

  assign running   = (state == ST_PRE) || (state == ST_FRAME) ||
                     (state == ST_TURN) || (state == ST_CAPT);
  assign phaseEnd  = running && (tick == TICK_LAST);
  assign bitEnd    = phaseEnd && (phase == 2'd2);
  assign frameLast = wrLatched ? WR_LAST : RD_LAST;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      tick  <= '0;
      phase <= 2'd0;
    end else if (!running) begin
      tick  <= '0;
      phase <= 2'd0;
    end else if (phaseEnd) begin
      tick  <= '0;
      phase <= (phase == 2'd2) ? 2'd0 : phase + 2'd1;
    end else begin
      tick <= tick + TW'(1);
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      state     <= ST_IDLE;
      bitCnt    <= '0;
      wrLatched <= 1'b0;
    end else begin
      case (state)
        ST_IDLE: begin
          bitCnt <= '0;
          if (startIn) begin
            state     <= ST_PRE;
            wrLatched <= isWrite;
          end
        end
        ST_PRE: if (bitEnd) begin
          if (bitCnt == PRE_LAST) begin
            state  <= ST_FRAME;
            bitCnt <= '0;
          end else begin
            bitCnt <= bitCnt + CW'(1);
          end
        end
        ST_FRAME: if (bitEnd) begin
          if (bitCnt == frameLast) begin
            state  <= wrLatched ? ST_FIN : ST_TURN;
            bitCnt <= '0;
          end else begin
            bitCnt <= bitCnt + CW'(1);
          end
        end
        ST_TURN: if (bitEnd) begin
          if (bitCnt == TURN_LAST) begin
            state  <= ST_CAPT;
            bitCnt <= '0;
          end else begin
            bitCnt <= bitCnt + CW'(1);
          end
        end
        ST_CAPT: if (bitEnd) begin
          if (bitCnt == DATA_LAST) begin
            state  <= ST_FIN;
            bitCnt <= '0;
          end else begin
            bitCnt <= bitCnt + CW'(1);
          end
        end
        default: begin
          state  <= ST_IDLE;
          bitCnt <= '0;
        end
      endcase
    end
  end

  always_comb begin
    stb            = '0;
    stb.load       = (state == ST_IDLE) && startIn;
    stb.shiftOut   = (state == ST_FRAME) && bitEnd;
    stb.driveFrame = (state == ST_FRAME);
    stb.grabErr    = (state == ST_TURN) && (bitCnt == '0) && bitEnd;
    stb.grabBit    = (state == ST_CAPT) && (phase == 2'd0) && phaseEnd;
    stb.finish     = (state == ST_FIN);
  end

  assign mdc    = running && (phase == 2'd1);
  assign mdioOe = !((state == ST_TURN) || (state == ST_CAPT));
  assign busy   = (state != ST_IDLE);
  assign done   = (state == ST_FIN);

endmodule

// File: rtl/mdio_master_dp.sv
module mdio_master_dp
  import mdio_master_pkg::*;
(
  input  logic              clk,
  input  logic              rstN,
  input  strobe_t           stb,
  input  logic              isWrite,
  input  logic [ADDR_W-1:0] phyAddr,
  input  logic [REG_W-1:0]  regAddr,
  input  logic [DATA_W-1:0] wrData,
  input  logic              mdioIn,
  output logic              mdioOut,
  output logic [DATA_W-1:0] rdData,
  output logic              errOut
);

  logic [FRAME_BITS-1:0] txShift;
  logic [DATA_W-1:0]     capReg;
  logic                  errFlag;
  logic                  curWrite;
  logic [DATA_W-1:0]     rdReg;
  logic                  errReg;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      txShift  <= '0;
      capReg   <= '0;
      errFlag  <= 1'b0;
      curWrite <= 1'b0;
    end else if (stb.load) begin
      txShift  <= {START_CODE, (isWrite ? OP_WRITE : OP_READ),
                   phyAddr, regAddr, WR_TURN, wrData};
      capReg   <= '0;
      errFlag  <= 1'b0;
      curWrite <= isWrite;
    end else begin
      if (stb.shiftOut) txShift <= {txShift[FRAME_BITS-2:0], 1'b0};
      if (stb.grabErr)  errFlag <= mdioIn;
      if (stb.grabBit)  capReg  <= {capReg[DATA_W-2:0], mdioIn};
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      rdReg  <= '0;
      errReg <= 1'b0;
    end else if (stb.finish) begin
      rdReg  <= (curWrite || errFlag) ? '0 : capReg;
      errReg <= !curWrite && errFlag;
    end
  end

  assign mdioOut = stb.driveFrame ? txShift[FRAME_BITS-1] : 1'b1;
  assign rdData  = stb.finish ? ((curWrite || errFlag) ? '0 : capReg) : rdReg;
  assign errOut  = stb.finish ? (!curWrite && errFlag) : errReg;

endmodule

// File: rtl/mdio_master.sv
module mdio_master
  import mdio_master_pkg::*;
#(
  parameter int PHASE_CLKS = 4,
  parameter int PRE_LEN    = 32
) (
  input  logic        clk,
  input  logic        rstN,
  input  logic        startIn,
  input  logic        isWrite,
  input  logic [4:0]  phyAddr,
  input  logic [4:0]  regAddr,
  input  logic [15:0] wrData,
  input  logic        mdioIn,
  output logic        busy,
  output logic        done,
  output logic [15:0] rdData,
  output logic        errOut,
  output logic        mdc,
  output logic        mdioOut,
  output logic        mdioOe
);

  strobe_t stb;

  mdio_master_ctrl #(
    .PHASE_CLKS(PHASE_CLKS),
    .PRE_LEN   (PRE_LEN)
  ) u_ctrl (
    .clk    (clk),
    .rstN   (rstN),
    .startIn(startIn),
    .isWrite(isWrite),
    .busy   (busy),
    .done   (done),
    .mdc    (mdc),
    .mdioOe (mdioOe),
    .stb    (stb)
  );

  mdio_master_dp u_dp (
    .clk    (clk),
    .rstN   (rstN),
    .stb    (stb),
    .isWrite(isWrite),
    .phyAddr(phyAddr),
    .regAddr(regAddr),
    .wrData (wrData),
    .mdioIn (mdioIn),
    .mdioOut(mdioOut),
    .rdData (rdData),
    .errOut (errOut)
  );

endmodule

// File: rtl/mdio_master_checker.sv
module mdio_master_checker (
  input logic        clk,
  input logic        rstN,
  input logic        startIn,
  input logic        busy,
  input logic        done,
  input logic [15:0] rdData,
  input logic        errOut,
  input logic        mdc,
  input logic        mdioOut,
  input logic        mdioOe
);

  p_idle_quiet_r1: assert property (@(posedge clk) disable iff (!rstN)
    !busy |-> (!mdc && mdioOe && mdioOut && !done));

  p_release_low_r6: assert property (@(posedge clk) disable iff (!rstN)
    $fell(mdioOe) |-> !mdc);

  p_mdc_only_busy_r4: assert property (@(posedge clk) disable iff (!rstN)
    $rose(mdc) |-> busy);

  p_err_zero_r7: assert property (@(posedge clk) disable iff (!rstN)
    errOut |-> (rdData == 16'h0000));

  p_done_single_r9: assert property (@(posedge clk) disable iff (!rstN)
    done |=> !done);

  p_done_busy_r9: assert property (@(posedge clk) disable iff (!rstN)
    done |-> busy);

  p_hold_busy_r10: assert property (@(posedge clk) disable iff (!rstN)
    (busy && !done) |=> busy);

  p_oe_back_r11: assert property (@(posedge clk) disable iff (!rstN)
    done |=> mdioOe);

endmodule

bind mdio_master mdio_master_checker u_chk (
  .clk    (clk),
  .rstN   (rstN),
  .startIn(startIn),
  .busy   (busy),
  .done   (done),
  .rdData (rdData),
  .errOut (errOut),
  .mdc    (mdc),
  .mdioOut(mdioOut),
  .mdioOe (mdioOe)
);

// File: tb/mdio_master_test.sv
`timescale 1ns/1ps
module mdio_master_test;

  localparam int P       = 2;
  localparam int LATENCY = 64 * 3 * P + 1;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        startIn = 1'b0;
  logic        isWrite = 1'b0;
  logic [4:0]  phyAddr = '0;
  logic [4:0]  regAddr = '0;
  logic [15:0] wrData = '0;
  logic        mdioIn = 1'b1;
  logic        busy, done, errOut, mdc, mdioOut, mdioOe;
  logic [15:0] rdData;

  int checks = 0;
  int errors = 0;
  bit finished = 0;

  // PHY model state
  logic [63:0] txBits;
  int          txCnt;
  int          rdEdges;
  bit          monOn;
  logic        phyErr;
  logic [15:0] phyData;
  int          doneCnt;

  always #5 clk = ~clk;

  mdio_master #(.PHASE_CLKS(P), .PRE_LEN(32)) uut (
    .clk(clk), .rstN(rstN), .startIn(startIn), .isWrite(isWrite),
    .phyAddr(phyAddr), .regAddr(regAddr), .wrData(wrData), .mdioIn(mdioIn),
    .busy(busy), .done(done), .rdData(rdData), .errOut(errOut),
    .mdc(mdc), .mdioOut(mdioOut), .mdioOe(mdioOe)
  );

  always @(posedge mdc) begin
    if (monOn) begin
      if (mdioOe) begin
        txBits = {txBits[62:0], mdioOut};
        txCnt  = txCnt + 1;
      end else begin
        rdEdges = rdEdges + 1;
        if (rdEdges == 1) mdioIn = phyErr;
        else if (rdEdges >= 2 && rdEdges <= 17) mdioIn = phyData[17 - rdEdges];
        else mdioIn = 1'b1;
      end
    end
  end

  always @(negedge clk) if (done) doneCnt = doneCnt + 1;

  task automatic check(input bit ok, input string req, input string what,
                       input longint act, input longint exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s: actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  task automatic runTxn(input bit wr, input logic [4:0] a, input logic [4:0] r,
                        input logic [15:0] d, input logic e,
                        input bit midStart);
    int lat;
    logic [63:0] expBits;
    logic [15:0] expRd;
    int d0;
    txBits = '0; txCnt = 0; rdEdges = 0; monOn = 1;
    phyErr = e; phyData = d; mdioIn = 1'b1;
    d0 = doneCnt;
    @(negedge clk);
    isWrite = wr; phyAddr = a; regAddr = r; wrData = d; startIn = 1'b1;
    @(posedge clk);
    lat = 1;
    @(negedge clk);
    startIn = 1'b0;
    check(busy === 1'b1, "R9", "busy after accept", busy, 1);
    while (!done && lat < 4000) begin
      if (midStart && lat == 50) begin
        startIn = 1'b1; isWrite = ~wr; phyAddr = ~a; regAddr = ~r; wrData = ~d;
      end else if (midStart && lat == 51) begin
        startIn = 1'b0;
      end
      @(posedge clk);
      lat++;
      @(negedge clk);
    end
    startIn = 1'b0;
    check(lat == LATENCY, "R4", "start-to-done edges", lat, LATENCY);
    if (wr) begin
      expBits = {32'hFFFF_FFFF, 2'b01, 2'b01, a, r, 2'b10, d};
      check(txCnt == 64, "R5", "driven edges on write", txCnt, 64);
      check(rdEdges == 0, "R5", "released edges on write", rdEdges, 0);
      check(txBits == expBits, "R3", "write frame bits", txBits, expBits);
      check(rdData == 16'h0 && errOut == 1'b0, "R9", "write result", {errOut, rdData}, 0);
    end else begin
      expBits = {18'h0, 32'hFFFF_FFFF, 2'b01, 2'b10, a, r};
      expRd = e ? 16'h0 : d;
      check(txCnt == 46, "R2", "driven edges on read", txCnt, 46);
      check(txBits[45:0] == expBits[45:0], "R3", "read header bits", txBits[45:0], expBits[45:0]);
      check(rdEdges == 18, "R6", "released edges on read", rdEdges, 18);
      check(errOut == e, "R7", "error flag", errOut, e);
      check(rdData == expRd, e ? "R7" : "R8", "read data", rdData, expRd);
    end
    @(negedge clk);
    monOn = 0;
    check(mdioOe === 1'b1, "R11", "oe after done", mdioOe, 1);
    check(done === 1'b0 && busy === 1'b0, "R9", "done single cycle", {done, busy}, 0);
    check(rdData == (wr ? 16'h0 : (e ? 16'h0 : d)), "R9", "rdData held", rdData,
          wr ? 0 : (e ? 0 : d));
    if (midStart) begin
      repeat (600) @(negedge clk);
      check(doneCnt == d0 + 1, "R10", "done count after busy start", doneCnt, d0 + 1);
      check(busy === 1'b0 && mdc === 1'b0, "R10", "no second access", {busy, mdc}, 0);
    end
  endtask

  initial begin
    #(200000 * 10);
    if (!finished) begin
      errors++;
      checks++;
      $display("FAIL watchdog expired");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    monOn = 0; txCnt = 0; rdEdges = 0; txBits = '0; doneCnt = 0;
    phyErr = 0; phyData = '0;
    repeat (3) @(negedge clk);
    // R1: reset state
    check(mdc === 1'b0 && mdioOe === 1'b1 && mdioOut === 1'b1, "R1", "reset lines",
          {mdc, mdioOe, mdioOut}, 3'b011);
    check(busy === 1'b0 && done === 1'b0, "R1", "reset status", {busy, done}, 0);
    rstN = 1'b1;
    repeat (3) @(negedge clk);
    check(mdc === 1'b0 && mdioOe === 1'b1 && busy === 1'b0, "R1", "idle after reset",
          {mdc, mdioOe, busy}, 3'b010);

    for (int i = 0; i < 32; i++) begin
      logic [15:0] dv;
      dv = 16'(i * 16'h0841) ^ 16'hA5C3;
      runTxn(1'b1, 5'(i), 5'(31 - i), dv, 1'b0, 1'b0);
      runTxn(1'b0, 5'(i), 5'(31 - i), ~dv, (i % 5 == 4), 1'b0);
    end
    // corner data patterns
    runTxn(1'b0, 5'd1, 5'd0, 16'hFFFF, 1'b0, 1'b0);
    runTxn(1'b0, 5'd1, 5'd31, 16'h0000, 1'b0, 1'b0);
    runTxn(1'b0, 5'd31, 5'd1, 16'hFFFF, 1'b1, 1'b0);
    runTxn(1'b1, 5'd31, 5'd31, 16'hFFFF, 1'b0, 1'b0);
    runTxn(1'b1, 5'd0, 5'd0, 16'h0000, 1'b0, 1'b0);
    // R10: start ignored while busy
    runTxn(1'b1, 5'd5, 5'd10, 16'h1234, 1'b0, 1'b1);
    runTxn(1'b0, 5'd9, 5'd3, 16'hBEEF, 1'b0, 1'b1);

    finished = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

endmodule